// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

This block is a first-in/first-out buffer that joins two unrelated clock domains. A producer pushes 18-bit words on the write clock and a consumer pops them on the read clock. Each side has its own active-low enable. The write and read positions are kept as binary counters that are one bit wider than the storage address. They cross between the domains as reflected-binary (gray) code through two-flop synchronizers.

Five active-low status outputs report the fill level: full, empty, almost-full, almost-empty and more-than-half-full. The almost thresholds come from two offset values driven by a separate configuration block. Every flag is registered in the domain where it asserts. It releases only after the opposite pointer has crossed over, which takes one to three cycles of the flag's own clock. The popped word lands in an output register. An active-low output enable forces the visible data bus to zero without touching the read position.

Top module: `dcfifo_pflag`

## Requirements
- R1: A word on `wr_data` is stored on a rising `wr_clk` edge when `wr_n` is 0 and `full_n` is 1. Words leave in the order they were stored.
- R2: On a rising `rd_clk` edge with `rd_n` = 0 and `empty_n` = 1, the oldest stored word is loaded into the output register. It is visible on `rd_data` right after that edge.
- R3: `full_n` is 0 exactly when the settled count equals DEPTH. A write attempted while `full_n` = 0 is dropped and does not move the write position.
- R4: `empty_n` is 0 exactly when the settled count is 0. A read attempted while `empty_n` = 0 is dropped, and `rd_data` keeps its last value.
- R5: `aempty_n` is 0 when the settled count is at most `ae_off`, and 1 when the count is `ae_off`+1 or more.
- R6: `afull_n` is 0 when the settled count is at least DEPTH−`af_off`, and 1 when the count is DEPTH−`af_off`−1 or less. The offset must be below DEPTH.
- R7: `half_n` is 0 when the settled count is at least DEPTH/2+1, and 1 when the count is DEPTH/2 or less.
- R8: While `rst_n` is 0 at clock edges, both positions return to zero. The flags then read: `full_n`, `afull_n`, `half_n` = 1 and `empty_n`, `aempty_n` = 0. The output register holds all zeros.
- R9: `rd_data` is all zeros while `oe_n` = 1. `oe_n` has no effect on which word the next read returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-domain clock |
| rd_clk | input | 1 | Read-domain clock |
| rst_n | input | 1 | Active-low reset, sampled synchronously in both domains |
| wr_n | input | 1 | Active-low write request |
| wr_data | input | DW | Word to store |
| rd_n | input | 1 | Active-low read request |
| oe_n | input | 1 | Active-low output enable; 1 forces rd_data to zero |
| af_off | input | AW | Almost-full offset x |
| ae_off | input | AW | Almost-empty offset y |
| rd_data | output | DW | Registered read word, gated by oe_n |
| full_n | output | 1 | Low when count equals DEPTH |
| empty_n | output | 1 | Low when count is zero |
| afull_n | output | 1 | Low when count is at least DEPTH−x |
| aempty_n | output | 1 | Low when count is at most y |
| half_n | output | 1 | Low when count exceeds DEPTH/2 |

## Verification
A corrupted pointer or a bad gray conversion shows up at the ports in two ways. The settled flags stop matching the count of accepted words. A popped word no longer matches the next entry in FIFO order. Both can be seen within a few cycles of the faulty operation. For this reason, the flags are compared with the arithmetic thresholds at every fill level from 0 to DEPTH, in both directions and under boundary offsets. Every popped word is compared during a concurrent run with unrelated clock rates. A dropped write or read at a boundary shows up as a stuck count, a missing word, or an output word that changed when it should have held.

// File: rtl/dcfifo_pkg.sv
// Shared helpers for the dual-clock FIFO: gray-code conversion on a
// fixed 16-bit container. Callers slice the result to their pointer width.
package dcfifo_pkg;
    localparam int GW = 16;

    function automatic logic [GW-1:0] to_gray(input logic [GW-1:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [GW-1:0] from_gray(input logic [GW-1:0] g);
        logic [GW-1:0] b;
        b[GW-1] = g[GW-1];
        for (int i = GW - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction
endpackage

// File: rtl/dcfifo_sync.sv
// Two-flop synchronizer for a gray-coded pointer.
// Assumes that only one bit of the input changes per source clock.
module dcfifo_sync #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    // Two-stage capture into the destination domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/dcfifo_wside.sv
// Write-domain control: write position and the full, almost-full and
// more-than-half flags. The count it uses comes from the synchronized
// read position, so it is conservative (never too low).
module dcfifo_wside
    import dcfifo_pkg::*;
#(
    parameter int DEPTH = 256,
    parameter int AW    = $clog2(DEPTH),
    parameter int PW    = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_n,
    input  logic [AW-1:0] af_off,
    input  logic [PW-1:0] rgray_s,
    output logic [PW-1:0] wgray,
    output logic [AW-1:0] waddr,
    output logic          wen_ok,
    output logic          full_n,
    output logic          afull_n,
    output logic          half_n
);
    localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);
    localparam logic [PW-1:0] HALF_P  = PW'(DEPTH / 2);

    logic [PW-1:0] wbin, wbin_nx, rbin_s, cnt_nx;

    assign wen_ok  = !wr_n && full_n;
    assign wbin_nx = wbin + PW'(wen_ok);
    assign rbin_s  = PW'(from_gray(GW'(rgray_s)));
    assign cnt_nx  = wbin_nx - rbin_s;
    assign waddr   = wbin[AW-1:0];

    // Advance the write position and publish its gray image.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wbin  <= '0;
            wgray <= '0;
        end else begin
            wbin  <= wbin_nx;
            wgray <= PW'(to_gray(GW'(wbin_nx)));
        end
    end

    // Register the write-side flags from the post-write count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full_n  <= 1'b1;
            afull_n <= 1'b1;
            half_n  <= 1'b1;
        end else begin
            full_n  <= (cnt_nx != DEPTH_P);
            afull_n <= (cnt_nx < (DEPTH_P - {1'b0, af_off}));
            half_n  <= (cnt_nx <= HALF_P);
        end
    end

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!full_n && !wr_n) |=> $stable(wgray));
    p_full_implies_afull_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !full_n |-> !afull_n);
    p_full_implies_half_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !full_n |-> !half_n);
endmodule

// File: rtl/dcfifo_rside.sv
// Read-domain control: read position and the empty and almost-empty flags.
// The count it uses comes from the synchronized write position, so it is
// conservative (never too high).
module dcfifo_rside
    import dcfifo_pkg::*;
#(
    parameter int DEPTH = 256,
    parameter int AW    = $clog2(DEPTH),
    parameter int PW    = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_n,
    input  logic [AW-1:0] ae_off,
    input  logic [PW-1:0] wgray_s,
    output logic [PW-1:0] rgray,
    output logic [AW-1:0] raddr,
    output logic          ren_ok,
    output logic          empty_n,
    output logic          aempty_n
);
    logic [PW-1:0] rbin, rbin_nx, wbin_s, cnt_nx;

    assign ren_ok  = !rd_n && empty_n;
    assign rbin_nx = rbin + PW'(ren_ok);
    assign wbin_s  = PW'(from_gray(GW'(wgray_s)));
    assign cnt_nx  = wbin_s - rbin_nx;
    assign raddr   = rbin[AW-1:0];

    // Advance the read position and publish its gray image.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rbin  <= '0;
            rgray <= '0;
        end else begin
            rbin  <= rbin_nx;
            rgray <= PW'(to_gray(GW'(rbin_nx)));
        end
    end

    // Register the read-side flags from the post-read count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            empty_n  <= 1'b0;
            aempty_n <= 1'b0;
        end else begin
            empty_n  <= (cnt_nx != '0);
            aempty_n <= (cnt_nx > {1'b0, ae_off});
        end
    end

    p_no_underflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!empty_n && !rd_n) |=> $stable(rgray));
    p_empty_implies_aempty_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !empty_n |-> !aempty_n);
endmodule

// File: rtl/dcfifo_mem.sv
// Storage array with a write port on the write clock and a registered
// read port on the read clock. The output register clears on reset.
module dcfifo_mem #(
    parameter int DW    = 18,
    parameter int DEPTH = 256,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          wclk,
    input  logic          rclk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [DEPTH];

    // Store accepted words.
    always_ff @(posedge wclk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Load the oldest word into the output register on an accepted read.
    always_ff @(posedge rclk) begin
        if (!rst_n)  rdata <= '0;
        else if (re) rdata <= mem[raddr];
    end
endmodule

// File: rtl/dcfifo_pflag.sv
// Dual-clock FIFO top. Connects the write control, the read control, the
// gray pointer synchronizers and the storage, and gates the output bus.
// Assumes that rst_n is held low across several edges of both clocks.
module dcfifo_pflag #(
    parameter int DW    = 18,
    parameter int DEPTH = 256,
    parameter int AW    = $clog2(DEPTH),
    parameter int PW    = AW + 1
) (
    input  logic          wr_clk,
    input  logic          rd_clk,
    input  logic          rst_n,
    input  logic          wr_n,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_n,
    input  logic          oe_n,
    input  logic [AW-1:0] af_off,
    input  logic [AW-1:0] ae_off,
    output logic [DW-1:0] rd_data,
    output logic          full_n,
    output logic          empty_n,
    output logic          afull_n,
    output logic          aempty_n,
    output logic          half_n
);
    logic [PW-1:0] wgray, rgray, wgray_s, rgray_s;
    logic [AW-1:0] waddr, raddr;
    logic          wen_ok, ren_ok;
    logic [DW-1:0] dout_q;

    dcfifo_wside #(.DEPTH(DEPTH), .AW(AW), .PW(PW)) u_wside (
        .clk(wr_clk), .rst_n(rst_n), .wr_n(wr_n), .af_off(af_off),
        .rgray_s(rgray_s), .wgray(wgray), .waddr(waddr), .wen_ok(wen_ok),
        .full_n(full_n), .afull_n(afull_n), .half_n(half_n));

    dcfifo_rside #(.DEPTH(DEPTH), .AW(AW), .PW(PW)) u_rside (
        .clk(rd_clk), .rst_n(rst_n), .rd_n(rd_n), .ae_off(ae_off),
        .wgray_s(wgray_s), .rgray(rgray), .raddr(raddr), .ren_ok(ren_ok),
        .empty_n(empty_n), .aempty_n(aempty_n));

    dcfifo_sync #(.W(PW)) u_w2r (.clk(rd_clk), .rst_n(rst_n), .d(wgray), .q(wgray_s));
    dcfifo_sync #(.W(PW)) u_r2w (.clk(wr_clk), .rst_n(rst_n), .d(rgray), .q(rgray_s));

    dcfifo_mem #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) u_mem (
        .wclk(wr_clk), .rclk(rd_clk), .rst_n(rst_n),
        .we(wen_ok), .waddr(waddr), .wdata(wr_data),
        .re(ren_ok), .raddr(raddr), .rdata(dout_q));

    // Output gate: the enable masks the bus only, never the read position.
    assign rd_data = oe_n ? '0 : dout_q;

    p_dout_hold_r4: assert property (@(posedge rd_clk) disable iff (!rst_n)
        (rd_n || !empty_n) |=> $stable(dout_q));
endmodule

// File: tb/test_dcfifo_pflag.sv
// Bench: sweeps every fill level of a 16-deep instance under several offset
// pairs, then runs a concurrent push/pop stream with unrelated clocks.
module test_dcfifo_pflag;
    localparam int WPER  = 10;
    localparam int RPER  = 14;
    localparam int DW    = 18;
    localparam int DEPTH = 16;
    localparam int AW    = $clog2(DEPTH);

    logic wr_clk = 0, rd_clk = 0, rst_n = 0;
    logic wr_n = 1, rd_n = 1, oe_n = 0;
    logic [DW-1:0] wr_data = '0;
    logic [AW-1:0] af_off = '0, ae_off = '0;
    logic [DW-1:0] rd_data;
    logic full_n, empty_n, afull_n, aempty_n, half_n;

    int n_chk = 0, n_bad = 0, cnt = 0;
    logic [DW-1:0] q[$];
    logic [DW-1:0] last;
    bit done = 0;

    always #(WPER/2) wr_clk = ~wr_clk;
    always #(RPER/2) rd_clk = ~rd_clk;

    dcfifo_pflag #(.DW(DW), .DEPTH(DEPTH)) i_dcfifo_pflag (
        .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .wr_n(wr_n),
        .wr_data(wr_data), .rd_n(rd_n), .oe_n(oe_n), .af_off(af_off),
        .ae_off(ae_off), .rd_data(rd_data), .full_n(full_n), .empty_n(empty_n),
        .afull_n(afull_n), .aempty_n(aempty_n), .half_n(half_n));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (4) @(negedge wr_clk);
        repeat (4) @(negedge rd_clk);
    endtask

    // Compare all five flags with the thresholds at a settled count c.
    task automatic check_flags(input int c);
        int x = int'(af_off), y = int'(ae_off);
        chk(full_n   == (c != DEPTH),      "R3 full_n",   full_n,   c != DEPTH);
        chk(empty_n  == (c != 0),          "R4 empty_n",  empty_n,  c != 0);
        chk(aempty_n == (c > y),           "R5 aempty_n", aempty_n, c > y);
        chk(afull_n  == (c < DEPTH - x),   "R6 afull_n",  afull_n,  c < DEPTH - x);
        chk(half_n   == (c <= DEPTH / 2),  "R7 half_n",   half_n,   c <= DEPTH / 2);
    endtask

    task automatic push(input logic [DW-1:0] d);
        @(negedge wr_clk);
        if (full_n) begin q.push_back(d); cnt++; end
        wr_n = 0; wr_data = d;
        @(negedge wr_clk);
        wr_n = 1;
    endtask

    task automatic pop(input string req);
        logic [DW-1:0] exp;
        bit ok;
        @(negedge rd_clk);
        ok = empty_n;
        exp = ok ? q.pop_front() : last;
        if (ok) cnt--;
        rd_n = 0;
        @(negedge rd_clk);
        rd_n = 1;
        if (!oe_n) chk(rd_data == exp, req, int'(rd_data), int'(exp));
        last = exp;
    endtask

    // Fill to DEPTH and drain to 0 with the given offsets, checking each level.
    task automatic sweep(input int x, input int y, input int seed);
        af_off = AW'(x); ae_off = AW'(y);
        settle(); check_flags(cnt);
        for (int i = 0; i < DEPTH; i++) begin
            push(DW'(seed * 64 + i));
            settle(); check_flags(cnt);
        end
        push(DW'(18'h3ABCD));          // R3: dropped at full
        settle(); check_flags(cnt);
        chk(cnt == DEPTH, "R3 count at full", cnt, DEPTH);
        for (int i = 0; i < DEPTH; i++) begin
            pop("R1 R2 order");
            settle(); check_flags(cnt);
        end
        pop("R4 hold when empty");      // dropped read: output holds
        settle(); check_flags(cnt);
    endtask

    initial begin
        last = '0;
        repeat (5) @(negedge rd_clk);
        // R8: reset state
        chk(full_n == 1 && afull_n == 1 && half_n == 1, "R8 write flags", {full_n, afull_n, half_n}, 3'b111);
        chk(empty_n == 0 && aempty_n == 0, "R8 read flags", {empty_n, aempty_n}, 0);
        chk(rd_data == '0, "R8 dout", int'(rd_data), 0);
        rst_n = 1;
        settle();

        sweep(3, 2, 1);
        sweep(0, 0, 2);
        sweep(DEPTH - 1, DEPTH - 1, 3);

        // R9: output enable masks the bus but not the read position
        af_off = 4'd3; ae_off = 4'd2;
        push(18'h11111); push(18'h22222); push(18'h33333);
        settle();
        oe_n = 1;
        pop("R9");
        chk(rd_data == '0, "R9 gated bus", int'(rd_data), 0);
        oe_n = 0;
        #1;
        chk(rd_data == 18'h11111, "R9 unmasked word", int'(rd_data), 18'h11111);
        pop("R9 next word after gated read");
        settle(); check_flags(cnt);
        pop("R1 drain");
        settle();

        // Concurrent stream with unrelated clocks
        fork
            begin
                int sent = 0;
                while (sent < 60) begin
                    @(negedge wr_clk);
                    if (full_n) begin
                        q.push_back(DW'(sent * 7 + 5)); sent++;
                        wr_n = 0; wr_data = DW'((sent - 1) * 7 + 5);
                    end else wr_n = 1;
                end
                @(negedge wr_clk); wr_n = 1;
            end
            begin
                int got = 0;
                logic [DW-1:0] exp;
                bit issued = 0;
                while (got < 60) begin
                    @(negedge rd_clk);
                    if (issued) begin
                        chk(rd_data == exp, "R1 R2 stream order", int'(rd_data), int'(exp));
                        got++;
                    end
                    issued = empty_n && (q.size() > 0);
                    if (issued) exp = q.pop_front();
                    rd_n = !issued;
                end
                rd_n = 1;
            end
        join
        cnt = 0;
        settle(); check_flags(0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(WPER * 150000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule